// File: doc/BRIEF.md
# Multi-Mode I2C Clock Phase Generator

This block produces the serial clock of an I2C controller. It draws SCL low and then releases it, and times each phase from a programmable cycle count. Three high/low count pairs are available, one each for standard, fast and high-speed operation. A speed-select input picks the active pair. When the build leaves out high-speed support, a high-speed request uses the fast pair instead. The high phase starts counting only once the bus line is seen high. A target that holds SCL low therefore stretches the clock without shortening the high time.

Two hold settings work on the data line around the clock edges. The transmit hold places a one-cycle strobe inside each low phase: the data shifter may change SDA only on that strobe. The receive hold delays the moment an incoming rising SDA is accepted while SCL is high. A falling SDA is never delayed. A sample strobe marks the middle of every high phase. All counts and the speed select are captured only while the block is disabled. Any count below six is raised to six.

Top module: `scl_timing_gen`

## Requirements
- R1: During reset and while disabled, `scl_low` is 0 and both `sda_shift` and `sample_stb` are 0.
- R2: Each low phase holds `scl_low` at 1 for exactly the selected low count of clock cycles. The first low phase begins one cycle after `enable` is sampled high.
- R3: The high phase lasts the selected high count of cycles, counted from the first cycle in which `scl_in` is seen high. A target stretching SCL low delays the count but does not shorten it.
- R4: Speed select encodings: 0 and 1 select the standard pair, 2 selects the fast pair, and 3 selects the high-speed pair.
- R5: With `HS_PRESENT` = 0, speed select 3 uses the fast pair.
- R6: Any high or low count below `MIN_CNT` (default 6) is used as `MIN_CNT`.
- R7: `sda_shift` pulses once per low phase, at cycle index min(tx hold, low count − 2), where index 0 is the first low cycle.
- R8: `sample_stb` pulses once per high phase, at cycle index (high count >> 1), where index 0 is the first cycle with `scl_in` high.
- R9: While `scl_in` is high, `sda_rx` rises only after `sda_in` has been high for the receive hold count of clock edges. A falling `sda_in` passes at once. While `scl_in` is low, `sda_rx` follows `sda_in`.
- R10: Counts, holds and speed select are captured only while `enable` is low. Changes made while enabled take effect at the next enable.
- R11: When `enable` is sampled low, `scl_low`, `sda_shift` and `sample_stb` are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator; configuration is frozen while high |
| speed_sel | input | 2 | 0/1 standard, 2 fast, 3 high-speed |
| std_hi | input | CNT_W | Standard-mode high count |
| std_lo | input | CNT_W | Standard-mode low count |
| fast_hi | input | CNT_W | Fast-mode high count |
| fast_lo | input | CNT_W | Fast-mode low count |
| hs_hi | input | CNT_W | High-speed high count |
| hs_lo | input | CNT_W | High-speed low count |
| tx_hold | input | HOLD_W | Cycles after SCL falls before SDA may change |
| rx_hold | input | HOLD_W | Cycles a rising SDA must persist while SCL is high |
| scl_in | input | 1 | Sensed SCL bus level (synchronised) |
| sda_in | input | 1 | Sensed SDA bus level (synchronised) |
| scl_low | output | 1 | 1 drives SCL low; 0 releases it |
| sda_shift | output | 1 | One-cycle strobe: SDA may change now |
| sample_stb | output | 1 | One-cycle strobe at mid high phase |
| sda_rx | output | 1 | Incoming SDA after receive hold filtering |

## Verification
The scoreboard measures every low run and every high run of the bus line against the expected clamped counts. A generator that starts its high count on release rather than on a high line gives a short high phase when the target stretches the clock. Counts of 2 and 3 check the clamp: an unclamped design gives runs shorter than six. An oversized transmit hold checks the pulse limit: without it the strobe would fall outside the low phase and never appear. A second instance built without high-speed support must run at the fast low time, and a count changed mid-run must not appear until re-enable. The receive filter is probed edge by edge: a rising SDA must wait exactly the hold count, and a falling SDA, or any SDA with SCL low, must pass at once.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_t;

   localparam logic [1:0] SPD_FAST = 2'd2;
   localparam logic [1:0] SPD_HS   = 2'd3;

endpackage

// File: rtl/scl_cnt_pick.sv
module scl_cnt_pick #(
   parameter int CNT_W      = 16,
   parameter int MIN_CNT    = 6,
   parameter bit HS_PRESENT = 1'b1
) (
   input  logic [1:0]       speed_sel,
   input  logic [CNT_W-1:0] std_hi,
   input  logic [CNT_W-1:0] std_lo,
   input  logic [CNT_W-1:0] fast_hi,
   input  logic [CNT_W-1:0] fast_lo,
   input  logic [CNT_W-1:0] hs_hi,
   input  logic [CNT_W-1:0] hs_lo,
   output logic [CNT_W-1:0] hi_cnt,
   output logic [CNT_W-1:0] lo_cnt
);
   import scl_gen_pkg::*;

   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

   logic [CNT_W-1:0] raw_hi, raw_lo;
   logic             use_hs;

   generate
      if (HS_PRESENT) begin : g_hs
         assign use_hs = (speed_sel == SPD_HS);
      end else begin : g_no_hs
         assign use_hs = 1'b0;
      end
   endgenerate

   always_comb begin
      if (use_hs) begin
         raw_hi = hs_hi;
         raw_lo = hs_lo;
      end else if (speed_sel == SPD_FAST || speed_sel == SPD_HS) begin
         raw_hi = fast_hi;
         raw_lo = fast_lo;
      end else begin
         raw_hi = std_hi;
         raw_lo = std_lo;
      end
   end

   assign hi_cnt = (raw_hi < FLOOR) ? FLOOR : raw_hi;
   assign lo_cnt = (raw_lo < FLOOR) ? FLOOR : raw_lo;

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
   parameter int CNT_W  = 16,
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  hi_cnt,
   input  logic [CNT_W-1:0]  lo_cnt,
   input  logic [HOLD_W-1:0] tx_hold,
   input  logic              scl_in,
   output logic              scl_low,
   output logic              sda_shift,
   output logic              sample_stb
);
   import scl_gen_pkg::*;

   localparam int EXT_W = (CNT_W > HOLD_W) ? CNT_W : HOLD_W;

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] tx_ext, lo_lim, tx_eff;
   logic [CNT_W-1:0] mid_idx;

   assign tx_ext  = EXT_W'(tx_hold);
   assign lo_lim  = EXT_W'(lo_cnt) - EXT_W'(2);
   assign tx_eff  = (tx_ext > lo_lim) ? lo_lim : tx_ext;
   assign mid_idx = hi_cnt >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
      end else if (!enable) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_OFF: begin
               phase_q <= PH_LOW;
               cnt_q   <= '0;
            end
            PH_LOW: begin
               if (cnt_q == lo_cnt - CNT_W'(1)) begin
                  phase_q <= PH_WAIT;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_WAIT: begin
               if (scl_in) begin
                  phase_q <= PH_HIGH;
                  cnt_q   <= CNT_W'(1);
               end
            end
            default: begin
               if (cnt_q == hi_cnt - CNT_W'(1)) begin
                  phase_q <= PH_LOW;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign scl_low    = (phase_q == PH_LOW);
   assign sda_shift  = (phase_q == PH_LOW) && (EXT_W'(cnt_q) == tx_eff);
   assign sample_stb = (phase_q == PH_HIGH) && (cnt_q == mid_idx);

endmodule

// File: rtl/sda_rx_hold.sv
module sda_rx_hold #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_in,
   input  logic              scl_in,
   input  logic [HOLD_W-1:0] rx_hold,
   output logic              sda_rx
);
   localparam logic [HOLD_W-1:0] RUN_MAX = '1;

   logic [HOLD_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!sda_in)
         run_q <= '0;
      else if (run_q != RUN_MAX)
         run_q <= run_q + HOLD_W'(1);
   end

   assign sda_rx = sda_in && (!scl_in || (run_q >= rx_hold));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
   parameter int CNT_W      = 16,
   parameter int HOLD_W     = 8,
   parameter int MIN_CNT    = 6,
   parameter bit HS_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        speed_sel,
   input  logic [CNT_W-1:0]  std_hi,
   input  logic [CNT_W-1:0]  std_lo,
   input  logic [CNT_W-1:0]  fast_hi,
   input  logic [CNT_W-1:0]  fast_lo,
   input  logic [CNT_W-1:0]  hs_hi,
   input  logic [CNT_W-1:0]  hs_lo,
   input  logic [HOLD_W-1:0] tx_hold,
   input  logic [HOLD_W-1:0] rx_hold,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_low,
   output logic              sda_shift,
   output logic              sample_stb,
   output logic              sda_rx
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("CNT_W must be at least 4");
      end
      if (MIN_CNT < 4 || MIN_CNT >= (1 << CNT_W)) begin : g_bad_min
         $error("MIN_CNT must be at least 4 and fit in CNT_W");
      end
      if (HOLD_W < 1 || HOLD_W > 16) begin : g_bad_hold_w
         $error("HOLD_W must lie in 1..16");
      end
   endgenerate

   logic [1:0]        spd_q;
   logic [CNT_W-1:0]  std_hi_q, std_lo_q, fast_hi_q, fast_lo_q, hs_hi_q, hs_lo_q;
   logic [HOLD_W-1:0] tx_q, rx_q;
   logic [CNT_W-1:0]  hi_sel, lo_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spd_q     <= '0;
         std_hi_q  <= '0;
         std_lo_q  <= '0;
         fast_hi_q <= '0;
         fast_lo_q <= '0;
         hs_hi_q   <= '0;
         hs_lo_q   <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
      end else if (!enable) begin
         spd_q     <= speed_sel;
         std_hi_q  <= std_hi;
         std_lo_q  <= std_lo;
         fast_hi_q <= fast_hi;
         fast_lo_q <= fast_lo;
         hs_hi_q   <= hs_hi;
         hs_lo_q   <= hs_lo;
         tx_q      <= tx_hold;
         rx_q      <= rx_hold;
      end
   end

   scl_cnt_pick #(
      .CNT_W      (CNT_W),
      .MIN_CNT    (MIN_CNT),
      .HS_PRESENT (HS_PRESENT)
   ) u_pick (
      .speed_sel (spd_q),
      .std_hi    (std_hi_q),
      .std_lo    (std_lo_q),
      .fast_hi   (fast_hi_q),
      .fast_lo   (fast_lo_q),
      .hs_hi     (hs_hi_q),
      .hs_lo     (hs_lo_q),
      .hi_cnt    (hi_sel),
      .lo_cnt    (lo_sel)
   );

   scl_phase_fsm #(
      .CNT_W  (CNT_W),
      .HOLD_W (HOLD_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .hi_cnt     (hi_sel),
      .lo_cnt     (lo_sel),
      .tx_hold    (tx_q),
      .scl_in     (scl_in),
      .scl_low    (scl_low),
      .sda_shift  (sda_shift),
      .sample_stb (sample_stb)
   );

   sda_rx_hold #(
      .HOLD_W (HOLD_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .sda_in  (sda_in),
      .scl_in  (scl_in),
      .rx_hold (rx_q),
      .sda_rx  (sda_rx)
   );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
   parameter int MIN_CNT = 6
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_in,
   input logic sda_in,
   input logic scl_low,
   input logic sda_shift,
   input logic sample_stb,
   input logic sda_rx
);
   logic [7:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run_q <= '0;
      else if (!scl_low)
         low_run_q <= '0;
      else if (low_run_q != 8'hFF)
         low_run_q <= low_run_q + 8'd1;
   end

   // R11 / R1: disabled generator goes quiet on the next cycle
   p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_low && !sda_shift && !sample_stb));

   // R6: an undisturbed low phase is never shorter than the floor
   p_low_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_low) && $past(enable)) |-> (low_run_q >= 8'(MIN_CNT)));

   // R7: the data-change strobe sits inside a low phase
   p_shift_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_shift |-> scl_low);

   // R8: the sample strobe only occurs with the line high and released
   p_sample_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (scl_in && !scl_low));

   // R9: a low SDA is never hidden by the receive hold
   p_rx_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sda_in |-> !sda_rx);

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.MIN_CNT(MIN_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .scl_in     (scl_in),
   .sda_in     (sda_in),
   .scl_low    (scl_low),
   .sda_shift  (sda_shift),
   .sample_stb (sample_stb),
   .sda_rx     (sda_rx)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;
   localparam int HW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [1:0] spd = 2'd1;
   logic [CW-1:0] s_hi = 10, s_lo = 12, f_hi = 7, f_lo = 9, h_hi = 6, h_lo = 7;
   logic [HW-1:0] txh = 0, rxh = 0;
   logic slave_hold = 1'b0;
   logic sda_in = 1'b1;
   logic scl_low, sda_shift, sample_stb, sda_rx;
   logic scl_low2, shift2, smp2, rx2;
   logic scl_line, scl_line2;

   int total = 0;
   int bad = 0;
   int exp_lo[$], exp_hi[$], exp_tx[$], exp_smp[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_line  = ~scl_low & ~slave_hold;
   assign scl_line2 = ~scl_low2;

   scl_timing_gen #(.CNT_W(CW), .HOLD_W(HW), .MIN_CNT(6), .HS_PRESENT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .enable(en), .speed_sel(spd),
      .std_hi(s_hi), .std_lo(s_lo), .fast_hi(f_hi), .fast_lo(f_lo),
      .hs_hi(h_hi), .hs_lo(h_lo), .tx_hold(txh), .rx_hold(rxh),
      .scl_in(scl_line), .sda_in(sda_in),
      .scl_low(scl_low), .sda_shift(sda_shift), .sample_stb(sample_stb), .sda_rx(sda_rx));

   scl_timing_gen #(.CNT_W(CW), .HOLD_W(HW), .MIN_CNT(6), .HS_PRESENT(1'b0)) uut_nohs (
      .clk(clk), .rst_n(rst_n), .enable(en), .speed_sel(spd),
      .std_hi(s_hi), .std_lo(s_lo), .fast_hi(f_hi), .fast_lo(f_lo),
      .hs_hi(h_hi), .hs_lo(h_lo), .tx_hold(txh), .rx_hold(rxh),
      .scl_in(scl_line2), .sda_in(sda_in),
      .scl_low(scl_low2), .sda_shift(shift2), .sample_stb(smp2), .sda_rx(rx2));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: measures phases at negedge and pops the scoreboard
   int lo_run = 0, hi_run = 0;
   bit seen_low = 0;
   always @(negedge clk) begin
      if (!en || !rst_n) begin
         lo_run = 0; hi_run = 0; seen_low = 0;
      end else if (scl_low) begin
         if (lo_run == 0 && hi_run > 0 && seen_low && exp_hi.size() > 0)
            chk("R3 high run", hi_run, exp_hi.pop_front());
         hi_run = 0;
         if (sda_shift && exp_tx.size() > 0)
            chk("R7 shift index", lo_run, exp_tx.pop_front());
         lo_run++;
      end else begin
         if (lo_run > 0) begin
            if (exp_lo.size() > 0) chk("R2 low run", lo_run, exp_lo.pop_front());
            seen_low = 1;
            lo_run = 0;
         end
         if (scl_line) begin
            if (sample_stb && seen_low && exp_smp.size() > 0)
               chk("R8 sample index", hi_run, exp_smp.pop_front());
            hi_run++;
         end
      end
   end

   function automatic int fl(input int v);
      return (v < 6) ? 6 : v;
   endfunction

   // driver: push expectations, run, wait for the monitor to drain them
   task automatic run_mode(input int hi, input int lo, input int tx, input int n);
      int he = fl(hi);
      int le = fl(lo);
      int te = (tx > le - 2) ? le - 2 : tx;
      for (int i = 0; i < n; i++) begin
         exp_lo.push_back(le);
         exp_hi.push_back(he);
         exp_tx.push_back(te);
         exp_smp.push_back(he >> 1);
      end
      @(negedge clk);
      en = 1'b1;
      while (exp_lo.size() + exp_hi.size() + exp_tx.size() + exp_smp.size() > 0)
         @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic stretch(input int k);
      @(negedge clk);
      while (!scl_low) @(negedge clk);
      slave_hold = 1'b1;
      while (scl_low) @(negedge clk);
      repeat (k) @(negedge clk);
      slave_hold = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int len2;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 scl_low in reset", int'(scl_low), 0);
      chk("R1 sda_shift in reset", int'(sda_shift), 0);
      chk("R1 sample_stb in reset", int'(sample_stb), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 scl_low disabled", int'(scl_low), 0);

      // R2 R3 R7 R8: standard pair via code 1
      spd = 2'd1; s_hi = 10; s_lo = 12; txh = 3;
      run_mode(10, 12, 3, 2);
      // R4: code 0 also selects standard
      spd = 2'd0; s_hi = 8; s_lo = 7; txh = 0;
      run_mode(8, 7, 0, 2);
      // R4: fast pair
      spd = 2'd2; f_hi = 7; f_lo = 9; txh = 0;
      run_mode(7, 9, 0, 2);
      // R4 R7: high-speed pair, tx hold limited to low-2
      spd = 2'd3; h_hi = 6; h_lo = 7; txh = 20;
      run_mode(6, 7, 20, 2);

      // R5: build without high speed falls back to fast pair
      @(negedge clk);
      en = 1'b1;
      while (!scl_low2) @(negedge clk);
      len2 = 0;
      while (scl_low2) begin len2++; @(negedge clk); end
      chk("R5 fallback low run", len2, 9);
      en = 1'b0;
      repeat (3) @(negedge clk);

      // R6: counts below the floor are raised to six
      spd = 2'd1; s_hi = 2; s_lo = 3; txh = 1;
      run_mode(2, 3, 1, 2);

      // R3: stretched clock keeps full high time
      s_hi = 8; s_lo = 8; txh = 2;
      fork
         run_mode(8, 8, 2, 2);
         stretch(5);
      join

      // R10: changes while enabled are ignored until re-enable
      s_hi = 10; s_lo = 12; txh = 2;
      fork
         run_mode(10, 12, 2, 3);
         begin repeat (4) @(negedge clk); s_hi = 20; s_lo = 14; end
      join
      run_mode(20, 14, 2, 2);

      // R11: dropping enable mid low phase releases SCL next cycle
      s_hi = 10; s_lo = 12;
      @(negedge clk); en = 1'b1;
      while (!scl_low) @(negedge clk);
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R11 scl released", int'(scl_low), 0);
      chk("R11 shift quiet", int'(sda_shift), 0);
      repeat (3) @(negedge clk);

      // R9: receive hold filter (SCL line high, generator disabled)
      rxh = 3; sda_in = 1'b0;
      repeat (3) @(negedge clk);
      sda_in = 1'b1; #1;
      chk("R9 rx after 0 edges", int'(sda_rx), 0);
      @(negedge clk); chk("R9 rx after 1 edge", int'(sda_rx), 0);
      @(negedge clk); chk("R9 rx after 2 edges", int'(sda_rx), 0);
      @(negedge clk); chk("R9 rx after 3 edges", int'(sda_rx), 1);
      sda_in = 1'b0; #1;
      chk("R9 rx fall immediate", int'(sda_rx), 0);
      slave_hold = 1'b1;
      @(negedge clk);
      sda_in = 1'b1; #1;
      chk("R9 rx passthrough scl low", int'(sda_rx), 1);
      slave_hold = 1'b0;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule